// File: doc/BRIEF.md
# Serial Character Receiver with Overrun and Break Detection

This block turns a serial receive line into parallel characters. A receive clock strobe (`rxc_en`, one system clock wide) marks each sampling instant. In asynchronous mode the block takes several strobes per bit, chosen from four oversampling factors. It confirms a start bit at mid-bit, samples each data bit, the optional parity bit and the stop bit at their centres, and then hands the character to a one-entry holding register. In synchronous mode every strobe carries one bit. Characters follow each other with no start or stop bits, and the block assumes it is already aligned to them.

A completed character raises a ready flag, and a one-cycle read strobe from the host lowers it. Parity, framing and overrun problems set sticky flags, which a separate clear pulse resets. When the line stays low through the stop positions of two characters in a row, a break output goes high in asynchronous mode. It falls as soon as the line is sampled high again.

Top module: `serial_rx`

## Requirements
- R1: In asynchronous mode, a low sample while idle begins a start bit. The line is sampled again half a bit period (factor/2 strobes) later. If it is high there, the block returns to idle without receiving anything.
- R2: The oversampling factor is selected by `fac_sel`: 0 gives 4, 1 gives 16, 2 gives 32 and 3 gives 64 strobes per bit. Each data bit is sampled one full factor after the previous sample.
- R3: Data arrive least significant bit first. `len_sel` 0..3 selects 5..8 data bits. `rx_data` holds the character right-justified, with the unused upper bits at zero.
- R4: When `par_en` is 1, a parity bit follows the data. `par_odd` 0 expects even parity and 1 expects odd parity. A mismatch sets `parity_err`.
- R5: A stop bit sampled low sets `framing_err`. The character is still delivered.
- R6: `rx_ready` goes to 1 in the cycle after a character is transferred to `rx_data`. It returns to 0 after a one-cycle `rd_stb`, and otherwise stays at 1.
- R7: If a character is transferred while `rx_ready` is still 1, the new character replaces the old one and `overrun_err` is set.
- R8: `overrun_err`, `parity_err` and `framing_err` stay set through later good characters. They are cleared only by an `err_clr` pulse.
- R9: In asynchronous mode, `brk_det` rises when two characters in a row are sampled entirely low, including their stop bits.
- R10: `brk_det` returns to 0 on the cycle after the first strobe that samples the line high.
- R11: In synchronous mode (`sync_mode`=1), each strobe samples one bit. The first strobe after idle takes bit 0. Characters, with the parity bit if enabled, are received back to back with no start or stop bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxc_en | input | 1 | Receive clock strobe, one sample per assertion |
| rxd | input | 1 | Serial receive line, idles high |
| sync_mode | input | 1 | 1 selects synchronous, 0 asynchronous |
| fac_sel | input | 2 | Oversampling factor select (4/16/32/64) |
| len_sel | input | 2 | Data length select (5..8 bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| rd_stb | input | 1 | Host read strobe, clears ready |
| err_clr | input | 1 | Clears the three error flags |
| rx_data | output | 8 | Last received character |
| rx_ready | output | 1 | Unread character present |
| overrun_err | output | 1 | Sticky overrun flag |
| parity_err | output | 1 | Sticky parity flag |
| framing_err | output | 1 | Sticky framing flag |
| brk_det | output | 1 | Break detected on the line |

## Verification
A wrong sample counter or a wrong bit index moves the sampling point away from mid-bit. That shows up as a shifted or wrong `rx_data` when the stop bit is reached, about one character time after the fault. A stuck state machine holds `rx_ready` low for good. Corrupted parity or break tracking shows within one or two characters, as a spurious or missing `parity_err` or `brk_det`. A missed clear of the break flag shows one cycle after the line goes high.

// File: rtl/serial_rx.sv
module serial_rx #(
  parameter int CW = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxc_en,
  input  logic       rxd,
  input  logic       sync_mode,
  input  logic [1:0] fac_sel,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rd_stb,
  input  logic       err_clr,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       overrun_err,
  output logic       parity_err,
  output logic       framing_err,
  output logic       brk_det
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;
  st_t st;

  logic [CW-1:0] cnt, fac, half;
  logic [2:0]    bitn;
  logic [7:0]    sh, sh_fin, dout;
  logic [3:0]    nbits;
  logic          acc, acc_fin, samp, last, load, par_bad;
  logic          cur_low, prev_low;

  always_comb begin
    case (fac_sel)
      2'd0:    fac = CW'(4);
      2'd1:    fac = CW'(16);
      2'd2:    fac = CW'(32);
      default: fac = CW'(64);
    endcase
  end

  assign half    = fac >> 1;
  assign nbits   = 4'd5 + {2'b00, len_sel};
  assign samp    = sync_mode | (cnt == fac);
  assign last    = bitn == 3'(nbits - 4'd1);
  assign sh_fin  = (st == S_DATA) ? {rxd, sh[7:1]} : sh;
  assign dout    = sh_fin >> (4'd8 - nbits);
  assign acc_fin = acc ^ ((st == S_PAR) & rxd);
  assign par_bad = par_en & (acc_fin != par_odd);
  assign load    = rxc_en & samp & ((st == S_STOP) |
                   (sync_mode & st == S_PAR) |
                   (sync_mode & st == S_DATA & last & ~par_en));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; sh <= '0; acc <= 1'b0;
      rx_data <= '0; rx_ready <= 1'b0;
      overrun_err <= 1'b0; parity_err <= 1'b0; framing_err <= 1'b0;
      brk_det <= 1'b0; cur_low <= 1'b0; prev_low <= 1'b0;
    end else begin
      if (rd_stb) rx_ready <= 1'b0;
      if (err_clr) begin
        overrun_err <= 1'b0; parity_err <= 1'b0; framing_err <= 1'b0;
      end
      if (rxc_en && !sync_mode && rxd) begin
        brk_det <= 1'b0; prev_low <= 1'b0; cur_low <= 1'b0;
      end
      if (load) begin
        rx_data  <= dout;
        rx_ready <= 1'b1;
        if (rx_ready && !rd_stb) overrun_err <= 1'b1;
        if (par_bad) parity_err <= 1'b1;
        if (st == S_STOP && !rxd) framing_err <= 1'b1;
      end
      if (rxc_en) begin
        case (st)
          S_IDLE:
            if (sync_mode) begin
              sh <= {rxd, 7'b0}; acc <= rxd; bitn <= 3'd1; st <= S_DATA;
            end else if (!rxd) begin
              cnt <= CW'(1); st <= S_START;
            end
          S_START:
            if (cnt == half) begin
              if (!rxd) begin
                st <= S_DATA; cnt <= CW'(1); bitn <= '0;
                sh <= '0; acc <= 1'b0; cur_low <= 1'b1;
              end else st <= S_IDLE;
            end else cnt <= cnt + CW'(1);
          S_DATA:
            if (samp) begin
              sh <= {rxd, sh[7:1]}; acc <= acc ^ rxd;
              cnt <= CW'(1); bitn <= bitn + 3'd1;
              if (last) st <= par_en ? S_PAR : (sync_mode ? S_IDLE : S_STOP);
            end else cnt <= cnt + CW'(1);
          S_PAR:
            if (samp) begin
              acc <= acc ^ rxd; cnt <= CW'(1);
              st <= sync_mode ? S_IDLE : S_STOP;
            end else cnt <= cnt + CW'(1);
          S_STOP:
            if (samp) begin
              st <= S_IDLE;
              if (!rxd && cur_low) begin
                if (prev_low) brk_det <= 1'b1;
                prev_low <= 1'b1;
              end else prev_low <= 1'b0;
            end else cnt <= cnt + CW'(1);
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_ready_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && !rd_stb |=> rx_ready);
  p_overrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_err) |-> $past(rx_ready));
  p_fe_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    framing_err && !err_clr |=> framing_err);
  p_pe_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err && !err_clr |=> parity_err);
  p_brk_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_det) |-> !$past(rxd));
  p_brk_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rxc_en && !sync_mode && rxd |=> !brk_det);

endmodule

// File: tb/sim_serial_rx.sv
module sim_serial_rx;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, rxc_en = 1'b1, rxd = 1'b1;
  logic sync_mode = 1'b0, par_en = 1'b0, par_odd = 1'b0, rd_stb = 1'b0, err_clr = 1'b0;
  logic [1:0] fac_sel = 2'd0, len_sel = 2'd3;
  logic [7:0] rx_data;
  logic rx_ready, overrun_err, parity_err, framing_err, brk_det;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_rx u0 (.clk, .rst_n, .rxc_en, .rxd, .sync_mode, .fac_sel, .len_sel,
    .par_en, .par_odd, .rd_stb, .err_clr, .rx_data, .rx_ready,
    .overrun_err, .parity_err, .framing_err, .brk_det);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int fac_of(logic [1:0] s);
    return (s == 0) ? 4 : (s == 1) ? 16 : (s == 2) ? 32 : 64;
  endfunction

  task automatic pulse_rd();
    @(negedge clk) rd_stb = 1; @(negedge clk) rd_stb = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) err_clr = 1; @(negedge clk) err_clr = 0;
  endtask

  task automatic send(logic [7:0] d, bit pflip, bit stopv);
    int f = fac_of(fac_sel);
    int n = 5 + int'(len_sel);
    logic x = 1'b0;
    @(negedge clk) rxd = 0;
    repeat (f - 1) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rxd = d[i]; x ^= d[i];
      repeat (f - 1) @(negedge clk);
    end
    if (par_en) begin
      @(negedge clk) rxd = (par_odd ? ~x : x) ^ pflip;
      repeat (f - 1) @(negedge clk);
    end
    @(negedge clk) rxd = stopv;
    repeat (f - 1) @(negedge clk);
    @(negedge clk) rxd = 1;
    repeat (f + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R6 reset ready", rx_ready, 0);
    chk("R8 reset flags", {overrun_err, parity_err, framing_err}, 0);
    chk("R9 reset break", brk_det, 0);
  endtask

  task automatic t_basic();
    fac_sel = 2'd1; len_sel = 2'd3;
    send(8'h5A, 0, 1);
    chk("R2 R3 x16 8-bit data", rx_data, 8'h5A);
    chk("R6 ready set", rx_ready, 1);
    pulse_rd();
    chk("R6 ready cleared by read", rx_ready, 0);
    fac_sel = 2'd2;
    send(8'h96, 0, 1);
    chk("R2 x32 data", rx_data, 8'h96);
    pulse_rd();
  endtask

  task automatic t_len5();
    fac_sel = 2'd0; len_sel = 2'd0;
    send(8'h13, 0, 1);
    chk("R3 5-bit right justified", rx_data, 8'h13);
    pulse_rd();
    len_sel = 2'd3;
  endtask

  task automatic t_parity();
    par_en = 1; par_odd = 0;
    send(8'hC3, 0, 1);
    chk("R4 even parity good", parity_err, 0);
    chk("R4 data with parity", rx_data, 8'hC3);
    pulse_rd();
    send(8'hC3, 1, 1);
    chk("R4 even parity bad", parity_err, 1);
    pulse_rd(); pulse_clr();
    chk("R8 clear parity", parity_err, 0);
    par_odd = 1;
    send(8'h07, 0, 1);
    chk("R4 odd parity good", parity_err, 0);
    chk("R4 odd data", rx_data, 8'h07);
    pulse_rd();
    par_en = 0; par_odd = 0;
  endtask

  task automatic t_frame();
    send(8'h7E, 0, 0);
    chk("R5 framing set", framing_err, 1);
    chk("R5 data still delivered", rx_data, 8'h7E);
    pulse_rd();
    send(8'h11, 0, 1);
    chk("R8 framing sticky", framing_err, 1);
    chk("R8 good char after error", rx_data, 8'h11);
    pulse_rd(); pulse_clr();
    chk("R8 framing cleared", framing_err, 0);
  endtask

  task automatic t_overrun();
    send(8'h21, 0, 1);
    chk("R7 no overrun on first", overrun_err, 0);
    send(8'h42, 0, 1);
    chk("R7 overrun set", overrun_err, 1);
    chk("R7 newer char kept", rx_data, 8'h42);
    pulse_clr();
    chk("R8 overrun cleared", overrun_err, 0);
    chk("R6 ready kept through clear", rx_ready, 1);
    pulse_rd();
  endtask

  task automatic t_false_start();
    fac_sel = 2'd1;
    @(negedge clk) rxd = 0;
    repeat (3) @(negedge clk);
    rxd = 1;
    repeat (40) @(negedge clk);
    chk("R1 false start ignored", rx_ready, 0);
    send(8'h81, 0, 1);
    chk("R1 receive after false start", rx_data, 8'h81);
    pulse_rd();
    fac_sel = 2'd0;
  endtask

  task automatic t_break();
    fac_sel = 2'd0; len_sel = 2'd3; par_en = 0;
    @(negedge clk) rxd = 0;
    repeat (60) @(negedge clk);
    chk("R9 no break after one char", brk_det, 0);
    repeat (40) @(negedge clk);
    chk("R9 break after two chars", brk_det, 1);
    chk("R9 break char data", rx_data, 8'h00);
    repeat (30) @(negedge clk);
    rxd = 1;
    @(negedge clk);
    chk("R10 break cleared on high", brk_det, 0);
    repeat (60) @(negedge clk);
  endtask

  task automatic t_sync();
    logic [15:0] stream = {8'h3C, 8'hA5};
    @(negedge clk) rst_n = 0;
    sync_mode = 1; len_sel = 2'd3; par_en = 0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      if (k == 8) begin
        chk("R11 sync first char", rx_data, 8'hA5);
        chk("R11 sync ready", rx_ready, 1);
      end
      rxd = stream[k];
      if (k == 0) rst_n = 1;
      @(negedge clk);
    end
    chk("R11 sync second char", rx_data, 8'h3C);
    chk("R7 sync overrun", overrun_err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_len5();
    t_parity();
    t_frame();
    t_overrun();
    t_false_start();
    t_break();
    t_sync();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog (all R): got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule